// File: doc/BRIEF.md
# Atomic Read-Modify-Write and Reservation Unit

This unit carries out the atomic memory instructions of a 64-bit core. It accepts one decoded 32-bit instruction word with the values of its two source registers. It then drives a simple memory port, with separate read and write strobes, a word/doubleword size flag and an acknowledge/error reply. The read, the combine and the write-back run as one sequence that no other request can break into. For each instruction the unit reports the value for the destination register, or a fault.

Read-modify-write instructions first fetch the memory operand at the rs1 address. They then store a combination of that operand with rs2 back to the same address, and return the fetched value. The unit also keeps one address reservation. A load-reserved sets it. A later store-conditional to the same address writes memory and clears it; any other store-conditional neither writes nor clears. While an instruction is in progress, `busy_o` is high and new requests are ignored.

Top module: `amo_unit`

## Requirements
- R1: An instruction is legal only when all of these hold: bits [6:0] equal 0x2F; bits [14:12] are 010 (32-bit word) or 011 (64-bit doubleword); bits [31:27] are one of 00000 add, 00001 swap, 00010 load-reserved, 00011 store-conditional, 01000 or, 01100 and, 11100 unsigned max; and, for load-reserved, bits [24:20] are zero. An illegal instruction completes with `fault_o` high, makes no memory access and leaves `rd_we_o` low.
- R2: A read-modify-write instruction first reads memory at the rs1 value, then writes to that same address. It completes with `rd_we_o` high, and `result_o` holds the value read. Read and write strobes are never high together, and the address is held until the acknowledge arrives.
- R3: Swap writes rs2 unchanged. Add writes (old + rs2), wrapping at the access width.
- R4: And writes (old AND rs2). Or writes (old OR rs2).
- R5: Unsigned max compares rs2 with the old value as unsigned numbers at the access width. It writes rs2 when rs2 >= old, and the old value otherwise.
- R6: A word access has `mem_dword_o` low. It writes only the low 32 bits, with `mem_wdata_o[63:32]` zero, and returns the old 32-bit value sign-extended to 64 bits.
- R7: Load-reserved reads memory and returns the value (sign-extended for a word). It makes the reservation valid at the rs1 address, replacing any earlier one, and makes no write.
- R8: Store-conditional with a valid reservation whose address equals rs1 writes rs2 (the low word for a word access), returns 0 and clears the reservation.
- R9: Store-conditional without a matching valid reservation makes no memory access and returns 1. The reservation is left unchanged.
- R10: When the memory reports an error on a read or a write, the instruction completes with `fault_o` high and `rd_we_o` low. No write follows a failed read, and the reservation is not changed.
- R11: `busy_o` is high from the cycle after acceptance through the cycle of `done_o`. Each instruction gives exactly one `done_o` pulse. A request presented while busy is ignored.
- R12: Reset clears the reservation, so a store-conditional as the first instruction after reset fails with result 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Instruction request, taken when not busy |
| instr_i | input | 32 | Instruction word |
| rs1_val_i | input | 64 | Address operand |
| rs2_val_i | input | 64 | Data operand |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_we_o | output | 1 | Destination register write enable, with done_o |
| fault_o | output | 1 | Instruction aborted, with done_o |
| result_o | output | 64 | Destination register value, valid with rd_we_o |
| mem_rd_o | output | 1 | Memory read strobe, held until acknowledge |
| mem_wr_o | output | 1 | Memory write strobe, held until acknowledge |
| mem_dword_o | output | 1 | Access size: 1 doubleword, 0 word |
| mem_addr_o | output | 64 | Access address |
| mem_wdata_o | output | 64 | Write data |
| mem_rdata_i | input | 64 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Access complete |
| mem_err_i | input | 1 | Access failed, valid with acknowledge |

## Verification
Each combine operation runs with operands whose upper and lower halves differ. This separates word from doubleword handling, shows sign extension of a negative old word, and shows that an add wraps within the word without touching the upper half. Unsigned max is given an rs2 whose low word is below an old word with its top bit set, which tells an unsigned compare from a signed or full-width one. Reservation sequences cover a matching store-conditional, a repeat after success, a mismatching address that must leave the reservation intact, and a reset in between. Read and write errors, illegal encodings, memory latency and a request injected while busy show abort handling and that only one instruction is taken.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int unsigned XLEN = 64;
  localparam int unsigned ILEN = 32;

  localparam logic [6:0] OPC_ATOMIC = 7'h2F;
  localparam logic [4:0] FN_ADD  = 5'b00000;
  localparam logic [4:0] FN_SWAP = 5'b00001;
  localparam logic [4:0] FN_LR   = 5'b00010;
  localparam logic [4:0] FN_SC   = 5'b00011;
  localparam logic [4:0] FN_OR   = 5'b01000;
  localparam logic [4:0] FN_AND  = 5'b01100;
  localparam logic [4:0] FN_MAXU = 5'b11100;
  localparam logic [2:0] SZ_WORD  = 3'b010;
  localparam logic [2:0] SZ_DWORD = 3'b011;

  typedef enum logic [2:0] {
    AMO_ADD, AMO_SWAP, AMO_OR, AMO_AND, AMO_MAXU, AMO_LR, AMO_SC
  } amo_op_e;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_RESP} amo_st_e;

  typedef struct packed {
    logic    legal;
    logic    dword;
    amo_op_e op;
  } amo_dec_t;

  // value returned to rd: word results are sign-extended
  function automatic logic [XLEN-1:0] fmt_ret(input logic dword, input logic [XLEN-1:0] v);
    return dword ? v : {{(XLEN/2){v[XLEN/2-1]}}, v[XLEN/2-1:0]};
  endfunction
endpackage

// File: rtl/amo_decode.sv
module amo_decode import amo_pkg::*; (
  input  logic [ILEN-1:0] instr_i,
  output amo_dec_t        dec_o
);
  logic fn_ok, sz_ok, lr_ok;
  logic unused_bits;
  assign unused_bits = ^{instr_i[26:25], instr_i[19:15], instr_i[11:7]};

  always_comb begin
    dec_o.op    = AMO_ADD;
    dec_o.dword = instr_i[12];
    fn_ok       = 1'b1;
    case (instr_i[31:27])
      FN_ADD:  dec_o.op = AMO_ADD;
      FN_SWAP: dec_o.op = AMO_SWAP;
      FN_LR:   dec_o.op = AMO_LR;
      FN_SC:   dec_o.op = AMO_SC;
      FN_OR:   dec_o.op = AMO_OR;
      FN_AND:  dec_o.op = AMO_AND;
      FN_MAXU: dec_o.op = AMO_MAXU;
      default: fn_ok = 1'b0;
    endcase
    sz_ok = (instr_i[14:12] == SZ_WORD) || (instr_i[14:12] == SZ_DWORD);
    lr_ok = (instr_i[31:27] != FN_LR) || (instr_i[24:20] == 5'd0);
    dec_o.legal = (instr_i[6:0] == OPC_ATOMIC) && fn_ok && sz_ok && lr_ok;
  end
endmodule

// File: rtl/amo_alu.sv
module amo_alu import amo_pkg::*; #(
  parameter int unsigned W = XLEN
) (
  input  amo_op_e      op_i,
  input  logic         dword_i,
  input  logic [W-1:0] old_i,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] wdata_o
);
  localparam int unsigned H = W / 2;
  logic [W-1:0] a, b, c;

  always_comb begin
    a = dword_i ? old_i : {{H{1'b0}}, old_i[H-1:0]};
    b = dword_i ? src_i : {{H{1'b0}}, src_i[H-1:0]};
    case (op_i)
      AMO_ADD:  c = a + b;
      AMO_OR:   c = a | b;
      AMO_AND:  c = a & b;
      AMO_MAXU: c = (b >= a) ? b : a;
      default:  c = b;  // swap and store-conditional
    endcase
    wdata_o = dword_i ? c : {{H{1'b0}}, c[H-1:0]};
  end
endmodule

// File: rtl/amo_rsv.sv
module amo_rsv import amo_pkg::*; #(
  parameter int unsigned AW = XLEN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic [AW-1:0] set_addr_i,
  input  logic [AW-1:0] cmp_addr_i,
  output logic          valid_o,
  output logic          hit_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_q  <= '0;
    end else if (set_i) begin
      valid_o <= 1'b1;
      addr_q  <= set_addr_i;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end
  end

  assign hit_o = valid_o && (addr_q == cmp_addr_i);
endmodule

// File: rtl/amo_unit.sv
module amo_unit import amo_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [ILEN-1:0] instr_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [XLEN-1:0] rs2_val_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            rd_we_o,
  output logic            fault_o,
  output logic [XLEN-1:0] result_o,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic            mem_dword_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  input  logic            mem_ack_i,
  input  logic            mem_err_i
);
  amo_st_e         state_q;
  amo_op_e         op_q;
  logic            dword_q, fault_q;
  logic [XLEN-1:0] addr_q, src_q, old_q, res_q;
  amo_dec_t        dec;
  logic            rsv_set, rsv_clr, rsv_valid, rsv_hit;
  logic            ack_ok;

  amo_decode i_decode (.instr_i(instr_i), .dec_o(dec));

  amo_alu #(.W(XLEN)) i_alu (
    .op_i(op_q), .dword_i(dword_q), .old_i(old_q), .src_i(src_q), .wdata_o(mem_wdata_o)
  );

  amo_rsv #(.AW(XLEN)) i_rsv (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(rsv_set), .clr_i(rsv_clr),
    .set_addr_i(addr_q), .cmp_addr_i(rs1_val_i), .valid_o(rsv_valid), .hit_o(rsv_hit)
  );

  assign ack_ok  = mem_ack_i && !mem_err_i;
  assign rsv_set = (state_q == ST_RD) && ack_ok && (op_q == AMO_LR);
  assign rsv_clr = (state_q == ST_WR) && ack_ok && (op_q == AMO_SC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= AMO_ADD;
      dword_q <= 1'b0;
      fault_q <= 1'b0;
      addr_q  <= '0;
      src_q   <= '0;
      old_q   <= '0;
      res_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          op_q    <= dec.op;
          dword_q <= dec.dword;
          addr_q  <= rs1_val_i;
          src_q   <= rs2_val_i;
          res_q   <= '0;
          fault_q <= 1'b0;
          if (!dec.legal) begin
            fault_q <= 1'b1;
            state_q <= ST_RESP;
          end else if (dec.op == AMO_SC) begin
            // conditional store decides at acceptance: no read needed
            if (rsv_hit) state_q <= ST_WR;
            else begin
              res_q   <= XLEN'(1);
              state_q <= ST_RESP;
            end
          end else begin
            state_q <= ST_RD;
          end
        end
        ST_RD: if (mem_ack_i) begin
          if (mem_err_i) begin
            fault_q <= 1'b1;
            state_q <= ST_RESP;
          end else begin
            old_q   <= mem_rdata_i;
            res_q   <= fmt_ret(dword_q, mem_rdata_i);
            state_q <= (op_q == AMO_LR) ? ST_RESP : ST_WR;
          end
        end
        ST_WR: if (mem_ack_i) begin
          if (mem_err_i) fault_q <= 1'b1;
          state_q <= ST_RESP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign mem_rd_o    = (state_q == ST_RD);
  assign mem_wr_o    = (state_q == ST_WR);
  assign mem_dword_o = dword_q;
  assign mem_addr_o  = addr_q;
  assign done_o      = (state_q == ST_RESP);
  assign rd_we_o     = done_o && !fault_q;
  assign fault_o     = done_o && fault_q;
  assign result_o    = res_q;

  logic unused_rsv;
  assign unused_rsv = rsv_valid;
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        done_o,
  input logic        rd_we_o,
  input logic        fault_o,
  input logic        mem_rd_o,
  input logic        mem_wr_o,
  input logic        mem_dword_o,
  input logic [63:0] mem_addr_o,
  input logic [63:0] mem_wdata_o,
  input logic        mem_ack_i,
  input logic        mem_err_i
);
  AST_RW_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R2
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) && !mem_ack_i |=> $stable(mem_addr_o)); // R2
  AST_WORD_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o && !mem_dword_o |-> mem_wdata_o[63:32] == 32'h0); // R6
  AST_ERR_ABORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) && mem_ack_i && mem_err_i |=> done_o && fault_o); // R10
  AST_FAULT_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !rd_we_o); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_rd_o && !mem_wr_o && !done_o); // R11
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R11
endmodule

bind amo_unit amo_unit_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .rd_we_o(rd_we_o), .fault_o(fault_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
  .mem_dword_o(mem_dword_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
  .mem_ack_i(mem_ack_i), .mem_err_i(mem_err_i)
);

// File: tb/test_amo_unit.sv
`timescale 1ns/1ps
module test_amo_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_instr = '0;
  logic [63:0] rs1 = '0, rs2 = '0;
  logic        busy_o, done_o, rd_we_o, fault_o, mem_rd_o, mem_wr_o, mem_dword_o;
  logic [63:0] result_o, mem_addr_o, mem_wdata_o;
  logic [63:0] mem_rdata = '0;
  logic        mem_ack = 1'b0, mem_err = 1'b0;

  always #4 clk = ~clk;

  amo_unit i_amo_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .instr_i(req_instr),
    .rs1_val_i(rs1), .rs2_val_i(rs2), .busy_o(busy_o), .done_o(done_o),
    .rd_we_o(rd_we_o), .fault_o(fault_o), .result_o(result_o),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_dword_o(mem_dword_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata),
    .mem_ack_i(mem_ack), .mem_err_i(mem_err)
  );

  int checks = 0, errors = 0;
  logic [63:0] mem [logic [63:0]];
  int lat = 0, wcnt = 0, nrd = 0, nwr = 0;
  logic err_rd = 1'b0, err_wr = 1'b0;
  logic [63:0] cur_addr = '0;
  logic m_rv = 1'b0;
  logic [63:0] m_ra = '0;

  localparam logic [63:0] A = 64'h1000, B = 64'h2000, C = 64'h3008;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [4:0] f5, input logic [2:0] f3,
                                      input logic [4:0] r2, input logic [6:0] opc);
    return {f5, 2'b00, r2, 5'd1, f3, 5'd2, opc};
  endfunction

  // memory responder: ack after lat cycles, word writes merge the low half
  initial forever begin
    @(negedge clk);
    mem_ack = 1'b0;
    mem_err = 1'b0;
    if (rst_n && (mem_rd_o || mem_wr_o)) begin
      if (wcnt >= lat) begin
        wcnt = 0;
        mem_ack = 1'b1;
        if (mem_addr_o !== cur_addr) chk(0, "R2", "access address", mem_addr_o, cur_addr);
        if (mem_rd_o) begin
          nrd++;
          mem_err = err_rd;
          mem_rdata = mem.exists(mem_addr_o) ? mem[mem_addr_o] : 64'h0;
        end else begin
          nwr++;
          mem_err = err_wr;
          if (!err_wr) begin
            logic [63:0] o;
            o = mem.exists(mem_addr_o) ? mem[mem_addr_o] : 64'h0;
            mem[mem_addr_o] = mem_dword_o ? mem_wdata_o : {o[63:32], mem_wdata_o[31:0]};
          end
        end
      end else wcnt++;
    end
  end

  task automatic do_op(input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b,
                       input bit extra, input string tag);
    logic [4:0] f5; logic [2:0] f3; logic dw, legal, ef, ew, rset, rclr, busy_bad;
    logic [63:0] old, ow, x, y, z, er, nm, got;
    int erd, ewr, n;
    f5 = ins[31:27]; f3 = ins[14:12]; dw = (f3 == 3'b011);
    legal = (ins[6:0] == 7'h2F) && (f3 == 3'b010 || f3 == 3'b011) &&
            (f5 inside {5'd0, 5'd1, 5'd2, 5'd3, 5'd8, 5'd12, 5'd28}) &&
            !(f5 == 5'd2 && ins[24:20] != 5'd0);
    old = mem.exists(a) ? mem[a] : 64'h0;
    ow  = dw ? old : {{32{old[31]}}, old[31:0]};
    er = '0; ef = 0; ew = 0; erd = 0; ewr = 0; nm = old; rset = 0; rclr = 0;
    if (!legal) ef = 1;
    else if (f5 == 5'd3) begin
      if (m_rv && m_ra == a) begin
        ewr = 1;
        if (err_wr) ef = 1;
        else begin ew = 1; er = 0; nm = dw ? b : {old[63:32], b[31:0]}; rclr = 1; end
      end else begin ew = 1; er = 64'd1; end
    end else begin
      erd = 1;
      if (err_rd) ef = 1;
      else if (f5 == 5'd2) begin ew = 1; er = ow; rset = 1; end
      else begin
        x = dw ? old : {32'h0, old[31:0]};
        y = dw ? b : {32'h0, b[31:0]};
        case (f5)
          5'd0:    z = x + y;
          5'd1:    z = y;
          5'd8:    z = x | y;
          5'd12:   z = x & y;
          default: z = (y >= x) ? y : x;
        endcase
        ewr = 1;
        if (err_wr) ef = 1;
        else begin ew = 1; er = ow; nm = dw ? z : {old[63:32], z[31:0]}; end
      end
    end
    if (rset) begin m_rv = 1; m_ra = a; end
    if (rclr) m_rv = 0;

    nrd = 0; nwr = 0; cur_addr = a; busy_bad = 0;
    @(negedge clk);
    req_valid = 1; req_instr = ins; rs1 = a; rs2 = b;
    @(negedge clk);
    req_valid = extra;
    if (extra) begin req_instr = enc(5'd0, 3'b011, 5'd0, 7'h2F); rs2 = 64'd1; end
    n = 0;
    while (done_o !== 1'b1 && n < 200) begin
      if (busy_o !== 1'b1) busy_bad = 1;
      @(negedge clk);
      req_valid = 0;
      n++;
    end
    req_valid = 0;
    chk(busy_o === 1'b1 && !busy_bad, "R11", "busy while in progress", {63'h0, busy_bad}, 64'h0);
    chk(done_o === 1'b1, tag, "done seen", {63'h0, done_o}, 64'h1);
    chk(fault_o === ef, tag, "fault", {63'h0, fault_o}, {63'h0, ef});
    chk(rd_we_o === ew, tag, "rd write", {63'h0, rd_we_o}, {63'h0, ew});
    if (ew) chk(result_o === er, tag, "result", result_o, er);
    chk(nrd == erd, tag, "read count", 64'(nrd), 64'(erd));
    chk(nwr == ewr, tag, "write count", 64'(nwr), 64'(ewr));
    got = mem.exists(a) ? mem[a] : 64'h0;
    chk(got === nm, tag, "memory", got, nm);
    @(negedge clk);
    chk(busy_o === 1'b0 && done_o === 1'b0, "R11", "single completion",
        {62'h0, busy_o, done_o}, 64'h0);
  endtask

  task automatic do_reset();
    rst_n = 0; req_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_rv = 0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk(busy_o === 0 && done_o === 0 && mem_rd_o === 0 && mem_wr_o === 0, "R11",
        "reset state", {60'h0, busy_o, done_o, mem_rd_o, mem_wr_o}, 64'h0);

    // R2 R3 add doubleword
    mem[A] = 64'h10;
    do_op(enc(5'd0, 3'b011, 5'd0, 7'h2F), A, 64'd5, 0, "R2");
    // R3 R6 swap word, negative old word
    mem[A] = 64'h1234_5678_8000_0001;
    do_op(enc(5'd1, 3'b010, 5'd0, 7'h2F), A, 64'hDEAD_BEEF_0000_0042, 0, "R6");
    // R3 R6 word add wraps inside the word
    mem[A] = 64'hAAAA_5555_FFFF_FFFF;
    do_op(enc(5'd0, 3'b010, 5'd0, 7'h2F), A, 64'h7777_0000_0000_0002, 0, "R3");
    // R4 and / or
    mem[A] = 64'hF0F0_0000_FFFF_0000;
    do_op(enc(5'd12, 3'b011, 5'd0, 7'h2F), A, 64'h0FF0_FFFF_00FF_FF00, 0, "R4");
    do_op(enc(5'd8, 3'b010, 5'd0, 7'h2F), A, 64'hFFFF_0000_0000_0001, 0, "R4");
    // R5 unsigned max
    mem[A] = 64'd5;
    do_op(enc(5'd28, 3'b011, 5'd0, 7'h2F), A, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R5");
    mem[A] = 64'h0000_0001_8000_0000;
    do_op(enc(5'd28, 3'b010, 5'd0, 7'h2F), A, 64'hFFFF_FFFF_0000_0010, 0, "R5");
    mem[A] = 64'h0000_0000_0000_0030;
    do_op(enc(5'd28, 3'b010, 5'd0, 7'h2F), A, 64'hFFFF_FFFF_0000_0030, 0, "R5");

    // R7 R8 R9 reservation
    mem[B] = 64'd77;
    do_op(enc(5'd2, 3'b011, 5'd0, 7'h2F), B, 64'h0, 0, "R7");
    do_op(enc(5'd3, 3'b011, 5'd0, 7'h2F), B, 64'd99, 0, "R8");
    do_op(enc(5'd3, 3'b011, 5'd0, 7'h2F), B, 64'd55, 0, "R9");
    mem[B] = 64'h0123_4567_F000_0000;
    do_op(enc(5'd2, 3'b010, 5'd0, 7'h2F), B, 64'h0, 0, "R7");
    do_op(enc(5'd3, 3'b010, 5'd0, 7'h2F), C, 64'h1111, 0, "R9");
    do_op(enc(5'd3, 3'b010, 5'd0, 7'h2F), B, 64'hFFFF_FFFF_0000_2222, 0, "R8");
    do_op(enc(5'd2, 3'b011, 5'd0, 7'h2F), B, 64'h0, 0, "R7");
    do_op(enc(5'd2, 3'b011, 5'd0, 7'h2F), C, 64'h0, 0, "R7");
    do_op(enc(5'd3, 3'b011, 5'd0, 7'h2F), B, 64'd1, 0, "R9");

    // R1 illegal encodings
    do_op(enc(5'd2, 3'b011, 5'd3, 7'h2F), B, 64'h0, 0, "R1");
    do_op(enc(5'd0, 3'b011, 5'd0, 7'h33), A, 64'h1, 0, "R1");
    do_op(enc(5'd0, 3'b000, 5'd0, 7'h2F), A, 64'h1, 0, "R1");
    do_op(enc(5'd4, 3'b011, 5'd0, 7'h2F), A, 64'h1, 0, "R1");

    // R10 memory errors
    err_rd = 1;
    do_op(enc(5'd0, 3'b011, 5'd0, 7'h2F), A, 64'h5, 0, "R10");
    do_op(enc(5'd2, 3'b011, 5'd0, 7'h2F), C, 64'h0, 0, "R10");
    err_rd = 0; err_wr = 1;
    do_op(enc(5'd1, 3'b011, 5'd0, 7'h2F), A, 64'h99, 0, "R10");
    err_wr = 0;
    do_op(enc(5'd2, 3'b011, 5'd0, 7'h2F), B, 64'h0, 0, "R7");
    err_wr = 1;
    do_op(enc(5'd3, 3'b011, 5'd0, 7'h2F), B, 64'h44, 0, "R10");
    err_wr = 0;
    do_op(enc(5'd3, 3'b011, 5'd0, 7'h2F), B, 64'h45, 0, "R8");

    // R11 latency and request while busy
    lat = 3;
    mem[A] = 64'h100;
    do_op(enc(5'd0, 3'b011, 5'd0, 7'h2F), A, 64'h23, 1, "R11");
    do_op(enc(5'd1, 3'b010, 5'd0, 7'h2F), A, 64'h8765_4321, 1, "R11");
    do_op(enc(5'd4, 3'b011, 5'd0, 7'h2F), A, 64'h1, 1, "R11");
    lat = 0;

    // R12 reset drops the reservation
    do_op(enc(5'd2, 3'b011, 5'd0, 7'h2F), B, 64'h0, 0, "R7");
    do_reset();
    do_op(enc(5'd3, 3'b011, 5'd0, 7'h2F), B, 64'h66, 0, "R12");

    finish_run();
  end
endmodule